// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is a SPI slave that stands in for a byte-wide non-volatile memory. A host selects it with an active-low chip select. The host then clocks in an 8-bit opcode, MSB first, and for array commands a 16-bit address. Data comes back on the serial output in the same bit order. The array is an on-chip RAM. In full-size builds `DEPTH` is 16384. Its default is 2048, which keeps elaboration light. Address bits above the array width are dropped.

Writes are guarded in two steps. First, an enable opcode sets a latch. Second, the write is buffered in a page and committed only on a clean deselect. The commit runs a self-timed busy period, which a cycle counter (`TWC` clocks) models. A status register reports the busy and latch state, holds two protect bits that fence part of the array, and holds a lock bit. Together with the write-protect pin, the lock bit freezes the status register.

The serial pins are sampled with the system clock `clk` through two-flop synchronisers. A serial clock phase must therefore last several `clk` cycles.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset, `so` is 0 and the status register reads 0x00.
- R2: Opcode 0x06 sets the enable latch (status bit 1) and opcode 0x04 clears it. Either takes effect when chip select rises after exactly 8 bits.
- R3: Opcode 0x03 followed by a 16-bit address returns bytes MSB first, starting with the falling serial clock edge after the last address bit. The address advances each byte and wraps from `DEPTH-1` to 0. Address bits at and above log2(`DEPTH`) are ignored.
- R4: Opcode 0x02 (page write) and opcode 0x01 (status write) are dropped, with no busy period, when the enable latch is clear.
- R5: Write data goes into a 64-byte page buffer, and the byte address wraps within that page. The array changes only if chip select rises after one or more whole data bytes. A rise that lands mid-byte discards the buffer.
- R6: An accepted write sets status bit 0 (busy) for `TWC` clock cycles from the deselect. When the busy period ends, bit 0 and the enable latch both clear.
- R7: While busy, any transaction whose opcode is not 0x05 is ignored. A read returns 0x00 and a write leaves the array untouched.
- R8: The protect bits (status bits 3:2) select which part of the array is fenced. 00 fences nothing, 01 the top quarter, 10 the top half and 11 everything. A page write that targets a fenced page is dropped, with no busy period and the latch left set.
- R9: Opcode 0x01 with one data byte writes status bits 7, 3 and 2 at the end of its busy period. If status bit 7 is set and `wp_n` is low, the command is refused.
- R10: While `hold_n` is low, serial clock edges are ignored and the transfer resumes intact afterwards.
- R11: Serial clock idle low (mode 0) and idle high (mode 3) both work. Input is sampled on rising edges and output changes on falling edges.
- R12: Opcode 0x05 returns the live status register repeatedly for as long as chip select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Active-low write-protect pin for the status register |
| hold_n | input | 1 | Active-low pause of serial activity |
| so | output | 1 | Serial data out |

## Verification
Each serial pin reaches the logic three `clk` cycles after it is driven: two synchroniser stages and one edge register. So a new `so` bit appears about three cycles after a falling serial clock edge. The bench holds each serial clock phase for six cycles and samples `so` just before the next rising edge, never near a transition. Busy-window checks are placed where timing is unambiguous. The first status byte of a long status read lands well inside the `TWC` window, and the third lands well past it. Reads issued during busy have their opcode complete inside the window, and the bench expects zeros from them.

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int DEPTH = 2048,
  parameter int PAGE  = 64,
  parameter int TWC   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  input  logic hold_n,
  output logic so
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(PAGE);
  localparam int CW = $clog2(TWC + 1);
  localparam logic [7:0] OP_WRSR = 8'h01, OP_WRITE = 8'h02, OP_READ = 8'h03,
                         OP_WRDI = 8'h04, OP_RDSR = 8'h05, OP_WREN = 8'h06;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q, wp_q, hold_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q <= '1; sck_q <= '0; si_q <= '0; wp_q <= '1; hold_q <= '1;
    end else begin
      cs_q <= {cs_q[1:0], cs_n}; sck_q <= {sck_q[1:0], sck};
      si_q <= {si_q[0], si}; wp_q <= {wp_q[0], wp_n}; hold_q <= {hold_q[0], hold_n};
    end

  wire cs_fall = cs_q[2] & ~cs_q[1];
  wire cs_rise = ~cs_q[2] & cs_q[1];
  wire live    = ~cs_q[1] & hold_q[1];
  wire rise    = live & ~sck_q[2] & sck_q[1];
  wire fall    = live & sck_q[2] & ~sck_q[1];
  wire [7:0] byte_in = {sh[6:0], si_q[1]};

  logic [4:0] n;
  logic [7:0] sh, op, so_sr, sr_new;
  logic [AW-1:0] addr;
  logic [AW-PW-1:0] page;
  logic [PAGE-1:0] pmask;
  logic [CW-1:0] cyc;
  logic ign, got, busy, wr_sr, wel, wpen;
  logic [1:0] bp;
  logic [7:0] mem [DEPTH];
  logic [7:0] pbuf [PAGE];

  wire [7:0] status = {wpen, 3'b000, bp, wel, busy};
  wire data_phase = (n >= 5'd24);
  wire hdr_addr   = (n >= 5'd8) && (n <= 5'd23);
  wire wr_byte    = rise && !ign && op == OP_WRITE && data_phase && n[2:0] == 3'd7;
  wire prot = (bp == 2'b11) || (bp == 2'b10 && addr[AW-1]) ||
              (bp == 2'b01 && (&addr[AW-1:AW-2]));
  wire go_wr = cs_rise && !ign && !busy && op == OP_WRITE && wel && got &&
               n == 5'd24 && !prot;
  wire go_sr = cs_rise && !ign && !busy && op == OP_WRSR && wel && n == 5'd16 &&
               !(wpen && !wp_q[1]);
  wire done  = busy && cyc == CW'(TWC - 1);

  assign so = so_sr[7];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n <= '0; sh <= '0; op <= '0; so_sr <= '0; sr_new <= '0; addr <= '0; page <= '0;
      pmask <= '0; cyc <= '0; ign <= 1'b0; got <= 1'b0; busy <= 1'b0; wr_sr <= 1'b0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0;
    end else begin
      if (cs_fall) begin
        n <= '0; got <= 1'b0; ign <= 1'b0; so_sr <= '0;
        if (!busy) pmask <= '0;
      end else if (rise) begin
        sh <= byte_in;
        n  <= (n == 5'd31) ? 5'd24 : n + 5'd1;
        if (n == 5'd7) begin
          op  <= byte_in;
          ign <= busy && byte_in != OP_RDSR;
        end
        if (hdr_addr) addr <= {addr[AW-2:0], si_q[1]};
        if (wr_byte) begin
          pmask[addr[PW-1:0]] <= 1'b1;
          got <= 1'b1;
          addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
        end
        if (!ign && op == OP_WRSR && n == 5'd15) sr_new <= byte_in;
      end else if (fall) begin
        if (!ign && op == OP_RDSR && n >= 5'd8 && n[2:0] == 3'd0)
          so_sr <= status;
        else if (!ign && !busy && op == OP_READ && n == 5'd24) begin
          so_sr <= mem[addr];
          addr  <= addr + 1'b1;
        end else
          so_sr <= {so_sr[6:0], 1'b0};
      end
      if (cs_rise && !ign && !busy && n == 5'd8) begin
        if (op == OP_WREN) wel <= 1'b1;
        if (op == OP_WRDI) wel <= 1'b0;
      end
      if (go_wr || go_sr) begin
        busy <= 1'b1; cyc <= '0; wr_sr <= go_sr; page <= addr[AW-1:PW];
      end
      if (busy) begin
        cyc <= cyc + 1'b1;
        if (done) begin
          busy <= 1'b0; wel <= 1'b0; pmask <= '0;
          if (wr_sr) {wpen, bp} <= {sr_new[7], sr_new[3:2]};
        end
      end
    end

  always_ff @(posedge clk) begin
    if (wr_byte) pbuf[addr[PW-1:0]] <= byte_in;
    if (busy && !wr_sr && cyc < CW'(PAGE) && pmask[cyc[PW-1:0]])
      mem[{page, cyc[PW-1:0]}] <= pbuf[cyc[PW-1:0]];
  end

  // R6
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel);
  // R6
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> cyc < CW'(TWC));
  // R4
  armed_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> wel);
  // R7
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !$rose(wel));
  // R8
  prot_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !wr_sr) |-> bp != 2'b11);
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q[1] && !cs_fall) |=> $stable(n));
endmodule

// File: tb/spi_eeprom_slave_test.sv
module spi_eeprom_slave_test;
  localparam int DEPTH = 2048;
  localparam int H = 6;
  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, wp_n = 1, hold_n = 1;
  logic so;
  int tests = 0, fails = 0;
  logic mode3 = 0;
  logic [7:0] model [DEPTH];
  logic known [DEPTH];
  logic [7:0] wbuf [64];
  logic m_wel = 0, m_wpen = 0;
  logic [1:0] m_bp = 0;
  int hold_at = -1;

  spi_eeprom_slave uut (.clk, .rst_n, .cs_n, .sck, .si, .wp_n, .hold_n, .so);

  always #2 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic fenced(input int a, input logic [1:0] b);
    case (b)
      2'b00: return 1'b0;
      2'b01: return a >= DEPTH * 3 / 4;
      2'b10: return a >= DEPTH / 2;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_sr(input logic wip);
    return {m_wpen, 3'b000, m_bp, m_wel, wip};
  endfunction

  task automatic wclk(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic begin_tx;
    sck = mode3; wclk(2); cs_n = 0; wclk(H);
  endtask

  task automatic end_tx;
    wclk(H); cs_n = 1; wclk(2 * H); sck = mode3; wclk(2);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      if (mode3) sck = 0;
      si = tx[i];
      wclk(H);
      rx[i] = so;
      if (i == hold_at) begin
        hold_n = 0; wclk(4);
        for (int k = 0; k < 3; k++) begin sck = ~sck; wclk(3); sck = ~sck; wclk(3); end
        hold_n = 1; wclk(4);
      end
      sck = 1;
      wclk(H);
      if (!mode3) sck = 0;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] r;
    begin_tx; xfer(op, 8, r); end_tx;
  endtask

  task automatic rdsr(input int nbytes, output logic [7:0] last, output logic [7:0] first);
    logic [7:0] r;
    begin_tx; xfer(8'h05, 8, r);
    for (int i = 0; i < nbytes; i++) begin
      xfer(8'h00, 8, r);
      if (i == 0) first = r;
      last = r;
    end
    end_tx;
  endtask

  task automatic wait_ready;
    logic [7:0] a, b;
    for (int i = 0; i < 30; i++) begin
      rdsr(1, a, b);
      if (!a[0]) break;
    end
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    begin_tx; xfer(8'h01, 8, r); xfer(v, 8, r); end_tx;
    if (m_wel && !(m_wpen && !wp_n)) begin
      m_wpen = v[7]; m_bp = v[3:2]; m_wel = 0; wait_ready;
    end
  endtask

  task automatic page_write(input int a, input int len, input int extra_bits);
    logic [7:0] r;
    int base;
    base = a & (DEPTH - 1) & ~63;
    begin_tx; xfer(8'h02, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
    for (int i = 0; i < len; i++) xfer(wbuf[i], 8, r);
    if (extra_bits > 0) xfer(8'hFF, extra_bits, r);
    end_tx;
    if (m_wel && len > 0 && extra_bits == 0 && !fenced(base, m_bp)) begin
      for (int i = 0; i < len; i++) begin
        model[base + (((a & 63) + i) & 63)] = wbuf[i];
        known[base + (((a & 63) + i) & 63)] = 1;
      end
      m_wel = 0;
      wait_ready;
    end
  endtask

  task automatic read_chk(input int a, input int len, input string tag);
    logic [7:0] r;
    int p;
    begin_tx; xfer(8'h03, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
    for (int i = 0; i < len; i++) begin
      xfer(8'h00, 8, r);
      p = (a + i) & (DEPTH - 1);
      if (known[p]) chk(r === model[p], tag, r, model[p]);
    end
    end_tx;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] a, b;
    int ad, ln, md;
    for (int i = 0; i < DEPTH; i++) known[i] = 0;
    void'($urandom(32'd1234));
    wclk(4); rst_n = 1; wclk(4);
    // R1 reset state
    chk(so === 1'b0, "R1 so at reset", so, 0);
    rdsr(1, a, b);
    chk(a === 8'h00, "R1 status at reset", a, 0);
    // R2 latch set and clear
    cmd(8'h06); rdsr(1, a, b);
    chk(a === 8'h02, "R2 enable sets bit1", a, 2);
    cmd(8'h04); rdsr(1, a, b);
    chk(a === 8'h00, "R2 disable clears bit1", a, 0);
    // fill first and last pages
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(i * 7 + 3);
    cmd(8'h06); m_wel = 1; page_write(0, 64, 0);
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(255 - i * 5);
    cmd(8'h06); m_wel = 1; page_write(DEPTH - 64, 64, 0);
    read_chk(0, 64, "R5 full page");
    // R3 wrap at array end, upper bits aliased
    read_chk(DEPTH - 2, 4, "R3 wrap at end");
    read_chk(16'h8000 | 5, 3, "R3 upper bits ignored");
    // R4 write without latch
    wbuf[0] = 8'hA5;
    page_write(16, 1, 0);
    rdsr(1, a, b);
    chk(a === 8'h00, "R4 no busy without latch", a, 0);
    read_chk(16, 1, "R4 array unchanged");
    // R6 and R12 busy window seen in one long status read
    cmd(8'h06);
    wbuf[0] = 8'h3C;
    begin_tx; xfer(8'h02, 8, a); xfer(8'h00, 8, a); xfer(8'h20, 8, a); xfer(8'h3C, 8, a); end_tx;
    model[32] = 8'h3C;
    rdsr(3, a, b);
    chk(b === 8'h03, "R6 busy and latch early", b, 3);
    chk(a === 8'h00, "R12 status after window", a, 0);
    read_chk(32, 1, "R6 committed byte");
    // R5 page wrap and partial byte
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    cmd(8'h06); m_wel = 1; page_write(62, 3, 0);
    read_chk(62, 2, "R5 tail of page");
    read_chk(0, 1, "R5 wrap in page");
    wbuf[0] = 8'hEE;
    cmd(8'h06); m_wel = 1; page_write(40, 1, 3);
    rdsr(1, a, b);
    chk(a === 8'h02, "R5 partial byte no commit", a, 2);
    read_chk(40, 1, "R5 partial byte data kept");
    cmd(8'h04); m_wel = 0;
    // R7 read and write during busy
    cmd(8'h06);
    begin_tx; xfer(8'h02, 8, a); xfer(8'h00, 8, a); xfer(8'h30, 8, a); xfer(8'h5A, 8, a); end_tx;
    model[48] = 8'h5A;
    begin_tx; xfer(8'h03, 8, a); xfer(8'h00, 8, a); xfer(8'h30, 8, a); xfer(8'h00, 8, a); end_tx;
    chk(a === 8'h00, "R7 read while busy", a, 0);
    wait_ready;
    cmd(8'h06);
    begin_tx; xfer(8'h02, 8, a); xfer(8'h00, 8, a); xfer(8'h31, 8, a); xfer(8'h77, 8, a); end_tx;
    model[49] = 8'h77;
    begin_tx; xfer(8'h02, 8, a); xfer(8'h00, 8, a); xfer(8'h30, 8, a); xfer(8'hC3, 8, a); end_tx;
    wait_ready;
    read_chk(48, 2, "R7 write while busy dropped");
    // R9 status write and pin lock
    cmd(8'h06); m_wel = 1; wrsr(8'h80);
    rdsr(1, a, b);
    chk(a === 8'h80, "R9 lock bit written", a, 8'h80);
    wp_n = 0;
    cmd(8'h06); m_wel = 1; wrsr(8'h8C);
    rdsr(1, a, b);
    chk(a === 8'h82, "R9 refused under pin", a, 8'h82);
    wp_n = 1;
    wrsr(8'h04);
    rdsr(1, a, b);
    chk(a === 8'h04, "R9 protect bits written", a, 4);
    // R8 fenced top quarter
    wbuf[0] = 8'h99;
    cmd(8'h06); m_wel = 1; page_write(DEPTH - 60, 1, 0);
    rdsr(1, a, b);
    chk(a === 8'h06, "R8 fenced write dropped", a, 6);
    read_chk(DEPTH - 60, 1, "R8 fenced data kept");
    wbuf[0] = 8'h44;
    page_write(8, 1, 0);
    read_chk(8, 1, "R8 unfenced write ok");
    cmd(8'h06); m_wel = 1; wrsr(8'h0C);
    wbuf[0] = 8'h01;
    cmd(8'h06); m_wel = 1; page_write(4, 1, 0);
    read_chk(4, 1, "R8 all fenced");
    wrsr(8'h00);
    m_wel = 0; cmd(8'h04);
    // R10 hold pause during read
    hold_at = 4;
    read_chk(0, 2, "R10 hold mid byte");
    hold_at = -1;
    // R11 mode 3 and random mix
    mode3 = 1;
    read_chk(0, 4, "R11 mode 3 read");
    rdsr(1, a, b);
    chk(a === 8'h00, "R11 mode 3 status", a, 0);
    for (int it = 0; it < 16; it++) begin
      md = $urandom_range(1, 0); mode3 = md[0];
      ad = $urandom_range(DEPTH - 1, 0); ln = $urandom_range(6, 1);
      for (int i = 0; i < ln; i++) wbuf[i] = 8'($urandom);
      cmd(8'h06); m_wel = 1; page_write(ad, ln, 0);
      read_chk(ad & ~63, 64, "R3 random readback");
    end
    mode3 = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule